// File: doc/BRIEF.md
# UART Transmit Buffer with Low-Water Request

This block sits between a host and a UART serializer. The host pushes bytes into a 32-entry first-in first-out store. The serializer sees the oldest byte on a show-ahead output and takes it with a pop strobe. When the number of bytes still waiting drops to a programmable threshold or below, the block raises a transmit-ready status. The threshold is written as a count of bytes *remaining*, not as a count of free slots. With a threshold of T, the host knows that DEPTH − T slots are free.

An interrupt line follows transmit-ready only while a software enable is set. The intended use is that the host clears the enable each time it services the request and sets it again after refilling. A separate transmitter-empty flag reports that the store is drained and the serializer has stopped shifting. A write into a full store is dropped and recorded in a sticky overflow bit, which is cleared by writing one to it.

Top module: `tx_lowater_fifo`

## Requirements
- R1: After reset the store is empty, the threshold is 2 and the interrupt enable is 0. Ready is 1, irq is 0, empty is 1 (with ser_busy low) and overflow is 0. With the reset threshold, ready holds for 2 stored bytes and drops at 3.
- R2: Bytes reach ser_data in the order they were written. ser_data shows the oldest stored byte whenever ser_avail is 1, and a pop moves to the next byte.
- R3: tx_ready is 1 exactly when the occupancy is less than or equal to the programmed threshold (written with cfg_we on cfg_thr). The flag is valid in the cycle after the write or pop edge.
- R4: irq is 1 only when tx_ready and the enable bit (cfg_ien, loaded by cfg_we) are both 1. Clearing the enable drops irq while ready stays high.
- R5: A write while 32 bytes are stored is discarded, and the stored contents do not change. Fullness is judged at the start of the cycle, even if a pop happens in that cycle.
- R6: Overflow status stays 1 until a cycle with ovf_clr high. If a new overflow happens in the same cycle as the clear, the overflow wins.
- R7: tx_empty is 1 only when the store holds no bytes and ser_busy is 0.
- R8: A pop while the store is empty has no effect.
- R9: Once ready is seen with threshold T, the host can write 32 − T bytes with no overflow. One more byte then overflows.
- R10: A write and a pop in the same cycle on a partly filled store both take effect, and the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write byte |
| cfg_we | input | 1 | Loads threshold and interrupt enable |
| cfg_thr | input | CNT_W | Remaining-bytes threshold |
| cfg_ien | input | 1 | Interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear for overflow status |
| ser_pop | input | 1 | Serializer takes the head byte |
| ser_busy | input | 1 | Serializer is still shifting a character |
| ser_data | output | DATA_W | Oldest stored byte |
| ser_avail | output | 1 | Store holds at least one byte |
| tx_ready | output | 1 | Occupancy at or below threshold |
| tx_empty | output | 1 | Store empty and serializer idle |
| irq | output | 1 | Ready request gated by enable |
| ovf_sticky | output | 1 | Sticky overflow status |

## Verification
Writes, pops, configuration loads and overflow clears all act through registers. Their effects on ser_data, ser_avail, tx_ready, irq and ovf_sticky are therefore due one clock after the edge that captures the stimulus. tx_empty also follows ser_busy combinationally within the same cycle. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, which is half a period after the capturing rising edge. For the ser_busy path it samples a short delay after the change. Expected values come from a queue model and an occupancy counter kept in the bench.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

   localparam int unsigned TLW_RESET_THR = 2;

   function automatic bit tlw_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tlw_cfg.sv
module tlw_cfg #(
   parameter int unsigned CNT_W   = 6,
   parameter int unsigned RST_THR = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_thr,
   input  logic             cfg_ien,
   output logic [CNT_W-1:0] thr_q,
   output logic             ien_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= CNT_W'(RST_THR);
         ien_q <= 1'b0;
      end else if (cfg_we) begin
         thr_q <= cfg_thr;
         ien_q <= cfg_ien;
      end
   end

endmodule

// File: rtl/tlw_store.sv
module tlw_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned PTR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp, wp_nx, rp_nx;

   generate
      if (tlw_pkg::tlw_is_pow2(DEPTH)) begin : g_wrap_nat
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign dout = mem[rp];

endmodule

// File: rtl/tlw_level.sv
module tlw_level #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             ovf_clr,
   output logic             push,
   output logic             pop,
   output logic [CNT_W-1:0] fill,
   output logic             ovf_q
);

   logic full, has_data, ovf_evt;

   assign full     = (fill == CNT_W'(DEPTH));
   assign has_data = (fill != '0);
   assign push     = wr_req & ~full;
   assign pop      = rd_req & has_data;
   assign ovf_evt  = wr_req & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else begin
         case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (ovf_evt) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
   end

endmodule

// File: rtl/tx_lowater_fifo.sv
module tx_lowater_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cfg_we,
   input  logic [CNT_W-1:0]  cfg_thr,
   input  logic              cfg_ien,
   input  logic              ovf_clr,
   input  logic              ser_pop,
   input  logic              ser_busy,
   output logic [DATA_W-1:0] ser_data,
   output logic              ser_avail,
   output logic              tx_ready,
   output logic              tx_empty,
   output logic              irq,
   output logic              ovf_sticky
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tx_lowater_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("tx_lowater_fifo: DATA_W must be positive");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("tx_lowater_fifo: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [CNT_W-1:0] thr_q, fill;
   logic             ien_q, push, pop;

   tlw_cfg #(.CNT_W(CNT_W), .RST_THR(tlw_pkg::TLW_RESET_THR)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
      .cfg_ien(cfg_ien), .thr_q(thr_q), .ien_q(ien_q)
   );

   tlw_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_valid), .rd_req(ser_pop),
      .ovf_clr(ovf_clr), .push(push), .pop(pop), .fill(fill),
      .ovf_q(ovf_sticky)
   );

   tlw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .din(wr_data), .dout(ser_data)
   );

   assign ser_avail = (fill != '0);
   assign tx_ready  = (fill <= thr_q);
   assign irq       = tx_ready & ien_q;
   assign tx_empty  = ~ser_avail & ~ser_busy;

endmodule

// File: rtl/tlw_checker.sv
module tlw_checker #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic             ser_pop,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] fill,
   input logic             ovf_sticky,
   input logic             tx_empty,
   input logic             ser_avail,
   input logic             tx_ready,
   input logic             irq
);

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   a_r5_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CNT_W'(DEPTH) && wr_valid && !ser_pop) |=>
      (fill == CNT_W'(DEPTH) && ovf_sticky));

   a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && !ovf_clr) |=> ovf_sticky);

   a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0 && ser_pop && !wr_valid) |=> (fill == '0));

   a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0 && fill != CNT_W'(DEPTH) && wr_valid && ser_pop) |=>
      $stable(fill));

   a_r7_empty_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> !ser_avail);

   a_r4_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> tx_ready);

endmodule

bind tx_lowater_fifo tlw_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .ser_pop(ser_pop),
   .ovf_clr(ovf_clr), .fill(fill), .ovf_sticky(ovf_sticky),
   .tx_empty(tx_empty), .ser_avail(ser_avail), .tx_ready(tx_ready),
   .irq(irq)
);

// File: tb/tx_lowater_fifo_tb.sv
module tx_lowater_fifo_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 8;
   localparam int DEPTH = 32;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, cfg_we = 1'b0, cfg_ien = 1'b0;
   logic          ovf_clr = 1'b0, ser_pop = 1'b0, ser_busy = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [CW-1:0] cfg_thr = '0;
   logic [DW-1:0] ser_data;
   logic          ser_avail, tx_ready, tx_empty, irq, ovf_sticky;

   int errors = 0;
   int checks = 0;
   int n_fill = 0;
   logic [DW-1:0] q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_lowater_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .cfg_we(cfg_we), .cfg_thr(cfg_thr), .cfg_ien(cfg_ien),
      .ovf_clr(ovf_clr), .ser_pop(ser_pop), .ser_busy(ser_busy),
      .ser_data(ser_data), .ser_avail(ser_avail), .tx_ready(tx_ready),
      .tx_empty(tx_empty), .irq(irq), .ovf_sticky(ovf_sticky)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [DW-1:0] d);
      wr_valid = 1'b1; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      if (n_fill < DEPTH) begin q.push_back(d); n_fill++; end
   endtask

   task automatic pop_chk(input string req);
      chk(req, {31'd0, ser_avail}, 32'd1);
      if (q.size() > 0) chk(req, ser_data, q[0]);
      ser_pop = 1'b1;
      @(negedge clk);
      ser_pop = 1'b0;
      if (n_fill > 0) begin void'(q.pop_front()); n_fill--; end
   endtask

   task automatic cfg(input int thr, input logic ien);
      cfg_we = 1'b1; cfg_thr = CW'(thr); cfg_ien = ien;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clr_ovf();
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
   endtask

   // R1 and R2: reset state, default threshold of 2, order of output
   task automatic t_reset();
      chk("R1 ready", {31'd0, tx_ready}, 32'd1);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 empty", {31'd0, tx_empty}, 32'd1);
      chk("R1 avail", {31'd0, ser_avail}, 32'd0);
      chk("R1 ovf", {31'd0, ovf_sticky}, 32'd0);
      push(8'hA1); push(8'hA2);
      chk("R1 ready at 2", {31'd0, tx_ready}, 32'd1);
      push(8'hA3);
      chk("R1 ready at 3", {31'd0, tx_ready}, 32'd0);
      for (int i = 0; i < 3; i++) pop_chk("R2 order");
      chk("R2 drained", {31'd0, ser_avail}, 32'd0);
   endtask

   // R8: pops on an empty store do nothing
   task automatic t_pop_empty();
      ser_pop = 1'b1;
      repeat (3) @(negedge clk);
      ser_pop = 1'b0;
      chk("R8 still empty", {31'd0, ser_avail}, 32'd0);
      push(8'h5A);
      chk("R8 one entry", {31'd0, ser_avail}, 32'd1);
      chk("R8 head", ser_data, 32'h5A);
      pop_chk("R8 pop");
      chk("R8 empty again", {31'd0, ser_avail}, 32'd0);
   endtask

   // R3: ready tracks occupancy against a threshold of 8
   task automatic t_threshold();
      cfg(8, 1'b0);
      for (int i = 0; i < 10; i++) begin
         push(DW'(8'h10 + i));
         chk("R3 fill up", {31'd0, tx_ready}, (n_fill <= 8) ? 32'd1 : 32'd0);
      end
      for (int i = 0; i < 10; i++) begin
         pop_chk("R3 drain");
         chk("R3 fill down", {31'd0, tx_ready}, (n_fill <= 8) ? 32'd1 : 32'd0);
      end
   endtask

   // R5 and R6: full store drops a write, sticky overflow, clear
   task automatic t_overflow();
      for (int i = 0; i < DEPTH; i++) push(DW'(8'h40 + i));
      chk("R5 not ready when full", {31'd0, tx_ready}, 32'd0);
      chk("R5 no ovf yet", {31'd0, ovf_sticky}, 32'd0);
      push(8'hEE);
      chk("R5 ovf set", {31'd0, ovf_sticky}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R6 ovf holds", {31'd0, ovf_sticky}, 32'd1);
      clr_ovf();
      chk("R6 ovf cleared", {31'd0, ovf_sticky}, 32'd0);
      for (int i = 0; i < DEPTH; i++) pop_chk("R5 contents");
      chk("R5 extra byte dropped", {31'd0, ser_avail}, 32'd0);
   endtask

   // R6: overflow in the same cycle as the clear keeps the bit set
   task automatic t_set_wins();
      for (int i = 0; i < DEPTH; i++) push(DW'(i));
      wr_valid = 1'b1; wr_data = 8'h77; ovf_clr = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; ovf_clr = 1'b0;
      chk("R6 set wins", {31'd0, ovf_sticky}, 32'd1);
      clr_ovf();
      for (int i = 0; i < DEPTH; i++) pop_chk("R6 contents");
   endtask

   // R4 and R9: interrupt at low water, refill window of DEPTH - thr
   task automatic t_window();
      cfg(8, 1'b1);
      for (int i = 0; i < DEPTH; i++) push(DW'(8'h80 + i));
      chk("R4 irq off when full", {31'd0, irq}, 32'd0);
      for (int i = 0; i < DEPTH - 9; i++) pop_chk("R9 drain");
      chk("R4 irq off at 9", {31'd0, irq}, 32'd0);
      pop_chk("R9 drain");
      chk("R4 irq at 8", {31'd0, irq}, 32'd1);
      cfg(8, 1'b0);
      chk("R4 irq masked", {31'd0, irq}, 32'd0);
      chk("R4 ready kept", {31'd0, tx_ready}, 32'd1);
      for (int i = 0; i < DEPTH - 8; i++) push(DW'(8'hC0 + i));
      chk("R9 no overflow", {31'd0, ovf_sticky}, 32'd0);
      push(8'hFF);
      chk("R9 next overflows", {31'd0, ovf_sticky}, 32'd1);
      clr_ovf();
      for (int i = 0; i < DEPTH; i++) pop_chk("R9 contents");
   endtask

   // R10: simultaneous write and pop
   task automatic t_simul();
      push(8'h01); push(8'h02); push(8'h03);
      for (int i = 0; i < 4; i++) begin
         chk("R10 head", ser_data, q[0]);
         wr_valid = 1'b1; wr_data = DW'(8'h20 + i); ser_pop = 1'b1;
         @(negedge clk);
         wr_valid = 1'b0; ser_pop = 1'b0;
         void'(q.pop_front());
         q.push_back(DW'(8'h20 + i));
      end
      for (int i = 0; i < 3; i++) pop_chk("R10 order");
      chk("R10 count kept", {31'd0, ser_avail}, 32'd0);
   endtask

   // R7: empty needs no data and an idle serializer
   task automatic t_empty();
      ser_busy = 1'b1; #1;
      chk("R7 busy", {31'd0, tx_empty}, 32'd0);
      ser_busy = 1'b0; #1;
      chk("R7 idle", {31'd0, tx_empty}, 32'd1);
      @(negedge clk);
      push(8'h33);
      chk("R7 data held", {31'd0, tx_empty}, 32'd0);
      pop_chk("R7 pop");
      chk("R7 drained", {31'd0, tx_empty}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pop_empty();
      t_threshold();
      t_overflow();
      t_set_wins();
      t_window();
      t_simul();
      t_empty();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule